// File: doc/BRIEF.md
# Segmented Virtually-Tagged Instruction Cache

A read-only instruction cache that sits between an instruction fetch unit and memory. The cache is split into 8 segments chosen by fetch address bits [7:5]. Each segment holds 64 lines, and any line can occupy any of the 64 slots of its segment, so each segment is fully associative. A line is 8 words of 32 bits, tagged with address bits [31:8]. Lookups use the modified virtual address directly. Translation and permission checks are done elsewhere, and their results arrive as per-fetch flags.

A fetch is held on the fetch port until `fetch_ready_o` is high. A hit completes in the cycle it is presented. A cacheable miss starts an 8-word burst on the memory port. The requested word is handed back in the cycle its beat arrives, and the whole line is installed in the cycle of the last beat. Fetches that must bypass the cache go to memory as single-word reads. Run-time controls select the replacement policy and reserve the lowest slots of every segment against replacement. A one-cycle command invalidates the whole cache.

Top module: `ic_top`

## Requirements
- R1: Reset clears every line's valid flag. After reset no memory request is pending, and the first enabled fetch to any address misses.
- R2: Word select is address bits [4:2], segment is bits [7:5] and tag is bits [31:8]. A line fill raises `mem_req_o` with `mem_burst_o`=1 and `mem_addr_o` equal to the fetch address with bits [4:0] cleared. It takes 8 beats, word 0 first.
- R3: A fetch whose segment holds a valid line with an equal tag gets `fetch_ready_o` and the stored word in the same cycle, with no memory request.
- R4: During a fill, `fetch_ready_o` rises in the cycle that the beat for the requested word is on `mem_rdata_i`, and that beat is returned.
- R5: With `enable_i`=0, every fetch is a single read: `mem_burst_o`=0 and `mem_addr_o` is the fetch address with bits [1:0] cleared. The stored lines are neither read nor changed, so re-enabling returns the earlier line contents.
- R6: A fetch with `fetch_abort_i`=1 completes at once with data 0 and causes no memory request and no allocation.
- R7: A miss allocates when `xlate_on_i`=0, whatever `fetch_cacheable_i` says. With `xlate_on_i`=1 it allocates only if `fetch_cacheable_i`=1, and otherwise makes a single read.
- R8: Each segment holds up to 64 lines at once. Lines with equal tags in different segments are independent.
- R9: With `rr_mode_i`=1, victims step upward through slots `lock_base_i`..63 and wrap back to `lock_base_i`. A pointer below the base is raised to the base. The pointer moves only on fills made in this mode.
- R10: Slots with index below `lock_base_i` are never overwritten by a fill in either mode.
- R11: With `rr_mode_i`=0, victims come from a free-running pseudo-random sequence forced into `lock_base_i`..63.
- R12: A one-cycle pulse on `inval_all_i` clears all 512 valid flags at the next edge. The pulse takes priority over a line install in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Cache enable |
| xlate_on_i | input | 1 | Address translation active, so the cacheable flag is honoured |
| rr_mode_i | input | 1 | 1 = round-robin victims, 0 = random victims |
| lock_base_i | input | 6 | First replaceable slot index |
| inval_all_i | input | 1 | Invalidate all lines |
| fetch_req_i | input | 1 | Fetch request, held until ready |
| fetch_addr_i | input | 32 | Fetch address |
| fetch_cacheable_i | input | 1 | Cacheable flag from translation |
| fetch_abort_i | input | 1 | Fetch aborted by translation |
| fetch_ready_o | output | 1 | Fetch complete this cycle |
| fetch_data_o | output | 32 | Fetched word |
| mem_req_o | output | 1 | Memory read in progress |
| mem_burst_o | output | 1 | 1 = 8-word line fill, 0 = single word |
| mem_addr_o | output | 32 | Memory read start address |
| mem_rvalid_i | input | 1 | Memory beat valid |
| mem_rdata_i | input | 32 | Memory beat data |

## Verification
The bench runs an 8-slot-per-segment build and keeps a shadow of line placement. It predicts hit or miss for every fetch from that shadow, from the round-robin rule and from the lock base. It fills one line for each word position, so a design that forwards the wrong beat, or forwards a beat late, returns stale data or the wrong latency. It changes memory contents while the cache is disabled, which shows whether disabled fetches leaked into the arrays or whether re-enabling lost the old lines. It also pushes many more fills than there are free slots through a segment in both replacement modes and then re-reads the locked lines. A victim selector that escapes the lock base, or a round-robin pointer that wraps to 0 instead of the base, turns those re-reads into memory requests.

// File: rtl/ic_pkg.sv
package ic_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_FILL = 2'd1, ST_SINGLE = 2'd2} ic_state_e;

  // maximal-length feedback masks, shift-left form
  function automatic logic [15:0] lfsr_taps(input int w);
    case (w)
      2:       return 16'h0003;
      3:       return 16'h0006;
      4:       return 16'h000C;
      5:       return 16'h0014;
      6:       return 16'h0030;
      7:       return 16'h0060;
      8:       return 16'h00B8;
      default: return 16'h0030;
    endcase
  endfunction
endpackage

// File: rtl/ic_victim.sv
module ic_victim import ic_pkg::*; #(
  parameter int WAYS = 64,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rr_mode_i,
  input  logic [WAY_W-1:0] lock_base_i,
  input  logic             advance_i,
  output logic [WAY_W-1:0] victim_o
);
  localparam logic [WAY_W-1:0] TAPS = WAY_W'(lfsr_taps(WAY_W));
  localparam logic [WAY_W-1:0] LAST = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] rr_q, lfsr_q, rr_eff, rnd_eff;

  assign rr_eff   = (rr_q < lock_base_i) ? lock_base_i : rr_q;
  assign rnd_eff  = (lfsr_q < lock_base_i) ? lock_base_i : lfsr_q;
  assign victim_o = rr_mode_i ? rr_eff : rnd_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q   <= '0;
      lfsr_q <= WAY_W'(1);
    end else begin
      lfsr_q <= {lfsr_q[WAY_W-2:0], ^(lfsr_q & TAPS)};
      if (advance_i && rr_mode_i)
        rr_q <= (rr_eff == LAST) ? lock_base_i : rr_eff + WAY_W'(1);
    end
  end
endmodule

// File: rtl/ic_store.sv
module ic_store #(
  parameter int SEGS   = 8,
  parameter int WAYS   = 64,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 24,
  localparam int SEG_W  = $clog2(SEGS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WRD_W  = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inval_i,
  input  logic [SEG_W-1:0]  lk_seg_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [WRD_W-1:0]  lk_word_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              wr_en_i,
  input  logic [SEG_W-1:0]  wr_seg_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i
);
  localparam int ENTRIES = SEGS * WAYS;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [WAYS-1:0]    match;
  logic [LINE_W-1:0]  sel_line;
  logic [SEG_W+WAY_W-1:0] wr_idx;

  assign wr_idx = {wr_seg_i, wr_way_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (inval_i) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx]  <= wr_tag_i;
      line_q[wr_idx] <= wr_line_i;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SEG_W+WAY_W-1:0] idx;
    assign idx      = {lk_seg_i, WAY_W'(w)};
    assign match[w] = valid_q[idx] && (tag_q[idx] == lk_tag_i);
  end

  always_comb begin
    sel_line = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) sel_line = sel_line | line_q[{lk_seg_i, WAY_W'(w)}];
  end

  assign hit_o  = |match;
  assign data_o = sel_line[int'(lk_word_i)*DATA_W +: DATA_W];
endmodule

// File: rtl/ic_top.sv
module ic_top import ic_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEGS   = 8,
  parameter int WAYS   = 64,
  parameter int WORDS  = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              xlate_on_i,
  input  logic              rr_mode_i,
  input  logic [WAY_W-1:0]  lock_base_i,
  input  logic              inval_all_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              fetch_cacheable_i,
  input  logic              fetch_abort_i,
  output logic              fetch_ready_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              mem_req_o,
  output logic              mem_burst_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WRD_W  = $clog2(WORDS);
  localparam int OFF_W  = BYTE_W + WRD_W;
  localparam int SEG_W  = $clog2(SEGS);
  localparam int TAG_W  = ADDR_W - OFF_W - SEG_W;
  localparam int LINE_W = WORDS * DATA_W;
  localparam logic [WRD_W-1:0] LAST_BEAT = WRD_W'(WORDS - 1);

  ic_state_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [WRD_W-1:0]  beat_q;
  logic [WAY_W-1:0]  victim_q, victim;
  logic [LINE_W-1:0] line_q;
  logic              start_fill, lk_hit, cacheable, last_beat;
  logic [DATA_W-1:0] lk_data;

  assign cacheable = !xlate_on_i || fetch_cacheable_i;
  assign last_beat = (st_q == ST_FILL) && mem_rvalid_i && (beat_q == LAST_BEAT);

  ic_store #(
    .SEGS(SEGS), .WAYS(WAYS), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inval_i   (inval_all_i),
    .lk_seg_i  (fetch_addr_i[OFF_W +: SEG_W]),
    .lk_tag_i  (fetch_addr_i[ADDR_W-1 -: TAG_W]),
    .lk_word_i (fetch_addr_i[BYTE_W +: WRD_W]),
    .hit_o     (lk_hit),
    .data_o    (lk_data),
    .wr_en_i   (last_beat),
    .wr_seg_i  (addr_q[OFF_W +: SEG_W]),
    .wr_way_i  (victim_q),
    .wr_tag_i  (addr_q[ADDR_W-1 -: TAG_W]),
    .wr_line_i ({mem_rdata_i, line_q[LINE_W-DATA_W-1:0]})
  );

  ic_victim #(.WAYS(WAYS)) u_vic (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rr_mode_i   (rr_mode_i),
    .lock_base_i (lock_base_i),
    .advance_i   (start_fill),
    .victim_o    (victim)
  );

  always_comb begin
    st_d          = st_q;
    start_fill    = 1'b0;
    fetch_ready_o = 1'b0;
    fetch_data_o  = '0;
    mem_req_o     = 1'b0;
    mem_burst_o   = 1'b0;
    mem_addr_o    = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (fetch_req_i) begin
          if (fetch_abort_i) begin
            fetch_ready_o = 1'b1;
          end else if (enable_i && lk_hit) begin
            fetch_ready_o = 1'b1;
            fetch_data_o  = lk_data;
          end else if (enable_i && cacheable) begin
            st_d       = ST_FILL;
            start_fill = 1'b1;
          end else begin
            st_d = ST_SINGLE;
          end
        end
      end
      ST_FILL: begin
        mem_req_o   = 1'b1;
        mem_burst_o = 1'b1;
        mem_addr_o  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        if (mem_rvalid_i) begin
          // critical word handed over as its beat passes
          if (fetch_req_i && beat_q == addr_q[BYTE_W +: WRD_W]) begin
            fetch_ready_o = 1'b1;
            fetch_data_o  = mem_rdata_i;
          end
          if (beat_q == LAST_BEAT) st_d = ST_IDLE;
        end
      end
      ST_SINGLE: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {addr_q[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
        if (mem_rvalid_i) begin
          fetch_ready_o = fetch_req_i;
          fetch_data_o  = mem_rdata_i;
          st_d          = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      beat_q   <= '0;
      victim_q <= '0;
      line_q   <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && st_d != ST_IDLE) begin
        addr_q   <= fetch_addr_i;
        beat_q   <= '0;
        victim_q <= victim;
      end
      if (st_q == ST_FILL && mem_rvalid_i) begin
        line_q[int'(beat_q)*DATA_W +: DATA_W] <= mem_rdata_i;
        beat_q <= beat_q + WRD_W'(1);
      end
    end
  end
endmodule

// File: rtl/ic_checks.sv
module ic_checks import ic_pkg::*; #(
  parameter int WAY_W  = 6,
  parameter int OFF_W  = 5,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              inval_i,
  input logic [WAY_W-1:0]  lock_base_i,
  input logic              fetch_req_i,
  input logic              fetch_abort_i,
  input logic              fetch_ready_i,
  input logic [DATA_W-1:0] fetch_data_i,
  input logic              mem_req_i,
  input logic              mem_burst_i,
  input logic [OFF_W-1:0]  mem_off_i,
  input logic [1:0]        st_i,
  input logic              hit_i,
  input logic [WAY_W-1:0]  victim_i
);
  a_r2_line_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_burst_i) |-> (mem_off_i == '0));

  a_r3_hit_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && fetch_req_i && !fetch_abort_i && enable_i && hit_i) |-> fetch_ready_i);

  a_r3_hit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && fetch_req_i && !fetch_abort_i && enable_i && hit_i) |=> !mem_req_i);

  a_r4_ready_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ready_i |-> fetch_req_i);

  a_r5_off_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && fetch_req_i && !fetch_abort_i && !enable_i) |=> (mem_req_i && !mem_burst_i));

  a_r6_abort_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && fetch_req_i && fetch_abort_i) |-> (fetch_ready_i && fetch_data_i == '0));

  a_r6_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && fetch_req_i && fetch_abort_i) |=> !mem_req_i);

  a_r10_victim_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_i >= lock_base_i);

  a_r12_inval_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !hit_i);
endmodule

bind ic_top ic_checks #(.WAY_W(WAY_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enable_i      (enable_i),
  .inval_i       (inval_all_i),
  .lock_base_i   (lock_base_i),
  .fetch_req_i   (fetch_req_i),
  .fetch_abort_i (fetch_abort_i),
  .fetch_ready_i (fetch_ready_o),
  .fetch_data_i  (fetch_data_o),
  .mem_req_i     (mem_req_o),
  .mem_burst_i   (mem_burst_o),
  .mem_off_i     (mem_addr_o[OFF_W-1:0]),
  .st_i          (st_q),
  .hit_i         (lk_hit),
  .victim_i      (victim)
);

// File: tb/sim_ic_top.sv
`timescale 1ns/1ps
module sim_ic_top;
  localparam int W = 8;
  localparam int WW = $clog2(W);

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, xl = 1'b0, rrm = 1'b1, inval = 1'b0;
  logic [WW-1:0] base = '0;
  logic req = 1'b0, cach = 1'b1, ab = 1'b0;
  logic [31:0] addr = '0;
  logic ready, mreq, mburst, mrvalid = 1'b0;
  logic [31:0] rdata, maddr, mrdata = '0;

  always #2.5 clk = ~clk;

  ic_top #(.WAYS(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .xlate_on_i(xl), .rr_mode_i(rrm),
    .lock_base_i(base), .inval_all_i(inval), .fetch_req_i(req), .fetch_addr_i(addr),
    .fetch_cacheable_i(cach), .fetch_abort_i(ab), .fetch_ready_o(ready), .fetch_data_o(rdata),
    .mem_req_o(mreq), .mem_burst_o(mburst), .mem_addr_o(maddr),
    .mem_rvalid_i(mrvalid), .mem_rdata_i(mrdata)
  );

  int total = 0, bad = 0;
  logic [31:0] mem_gen = '0;
  int n_txn = 0;
  logic [31:0] last_addr = '0;
  logic last_burst = 1'b0;

  // shadow of line placement (round-robin mode only)
  bit          sv   [8][W];
  int          stag [8][W];
  logic [31:0] sgen [8][W];
  int          rr_p = 0;

  function automatic logic [31:0] memword(input logic [31:0] a, input logic [31:0] g);
    return {a[31:2], 2'b00} ^ 32'h3C00_0000 ^ g;
  endfunction

  function automatic logic [31:0] mk(input int tg, input int seg, input int wd);
    return {tg[23:0], seg[2:0], wd[2:0], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  // memory model: all actions on falling edges
  initial begin
    forever begin
      @(negedge clk iff mreq);
      n_txn++;
      last_addr  = maddr;
      last_burst = mburst;
      for (int k = 0; k < (mburst ? 8 : 1); k++) begin
        if (k != 0) @(negedge clk);
        mrvalid = 1'b1;
        mrdata  = memword(last_addr + 32'(4*k), mem_gen);
        @(posedge clk);
      end
      @(negedge clk);
      mrvalid = 1'b0;
    end
  end

  task automatic fetch(input logic [31:0] a, input bit c, input bit abrt,
                       output logic [31:0] d, output int cyc, output int nt);
    int n0;
    @(negedge clk);
    n0 = n_txn; req = 1'b1; addr = a; cach = c; ab = abrt; cyc = 0;
    #1;
    while (!ready) begin
      @(negedge clk); #1; cyc++;
      if (cyc > 200) begin chk(1'b0, "R4 fetch hung", 64'(cyc), 0); break; end
    end
    d = rdata;
    @(negedge clk);
    req = 1'b0; ab = 1'b0;
    while (mreq) @(negedge clk);
    nt = n_txn - n0;
  endtask

  task automatic do_inval();
    @(negedge clk); inval = 1'b1;
    @(negedge clk); inval = 1'b0;
    for (int s = 0; s < 8; s++) for (int j = 0; j < W; j++) sv[s][j] = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input bit c, input string rq);
    int seg, tg, hs, v, cyc, nt;
    logic [31:0] d;
    bit exp_hit, alloc;
    seg = int'(a[7:5]); tg = int'(a[31:8]); hs = -1;
    for (int j = 0; j < W; j++) if (sv[seg][j] && stag[seg][j] == tg) hs = j;
    exp_hit = en && hs >= 0;
    alloc   = en && !exp_hit && (!xl || c);
    fetch(a, c, 1'b0, d, cyc, nt);
    if (exp_hit) begin
      chk(nt == 0 && cyc == 0, {rq, " hit"}, 64'({nt[15:0], cyc[15:0]}), 0);
      chk(d == memword(a, sgen[seg][hs]), {rq, " hit data"}, 64'(d), 64'(memword(a, sgen[seg][hs])));
    end else if (alloc) begin
      chk(nt == 1 && last_burst && last_addr == {a[31:5], 5'b0}, {rq, " R2 fill"},
          64'({nt[7:0], last_burst, last_addr}), 64'({8'd1, 1'b1, a[31:5], 5'b0}));
      chk(cyc == int'(a[4:2]) + 1, {rq, " R4 forward cycle"}, 64'(cyc), 64'(int'(a[4:2]) + 1));
      chk(d == memword(a, mem_gen), {rq, " R4 forward data"}, 64'(d), 64'(memword(a, mem_gen)));
      v = (rr_p < int'(base)) ? int'(base) : rr_p;
      sv[seg][v] = 1'b1; stag[seg][v] = tg; sgen[seg][v] = mem_gen;
      rr_p = (v == W - 1) ? int'(base) : v + 1;
    end else begin
      chk(nt == 1 && !last_burst && last_addr == {a[31:2], 2'b0}, {rq, " single"},
          64'({nt[7:0], last_burst, last_addr}), 64'({8'd1, 1'b0, a[31:2], 2'b0}));
      chk(d == memword(a, mem_gen), {rq, " single data"}, 64'(d), 64'(memword(a, mem_gen)));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cyc, nt;
    int locked [5];
    for (int s = 0; s < 8; s++) for (int j = 0; j < W; j++) sv[s][j] = 1'b0;
    #12; @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!mreq && !ready, "R1 reset idle", 64'({mreq, ready}), 0);

    // disabled path, twice: never cached
    access(mk(5, 2, 3), 1'b1, "R5");
    access(mk(5, 2, 3), 1'b1, "R5");

    @(negedge clk); en = 1'b1;
    access(mk(5, 2, 3), 1'b1, "R1");   // nothing valid after reset

    // one line per requested word position
    for (int w = 0; w < 8; w++) access(mk(32'h40 + w, 1, w), 1'b1, "R4");
    for (int l = 0; l < 8; l++)
      for (int w = 0; w < 8; w++) access(mk(32'h40 + l, 1, w), 1'b1, "R3");

    // aborted fetch on a missing line
    fetch(mk(32'h77, 4, 1), 1'b1, 1'b1, d, cyc, nt);
    chk(nt == 0 && cyc == 0 && d == 0, "R6 abort", 64'({nt[7:0], cyc[7:0], d}), 0);
    access(mk(32'h77, 4, 1), 1'b1, "R6");

    // memory changes while disabled; old line survives re-enable
    mem_gen = 32'h0000_F0F0;
    @(negedge clk); en = 1'b0;
    access(mk(32'h41, 1, 2), 1'b1, "R5");
    @(negedge clk); en = 1'b1;
    access(mk(32'h41, 1, 2), 1'b1, "R5");

    // cacheable rule
    @(negedge clk); xl = 1'b1;
    access(mk(32'h90, 0, 0), 1'b0, "R7");
    access(mk(32'h90, 0, 0), 1'b0, "R7");
    access(mk(32'h91, 0, 0), 1'b1, "R7");
    @(negedge clk); xl = 1'b0;
    access(mk(32'h92, 0, 1), 1'b0, "R7");
    access(mk(32'h92, 0, 1), 1'b0, "R7");

    // invalidate all
    access(mk(32'h91, 0, 0), 1'b1, "R12");
    do_inval();
    access(mk(32'h91, 0, 0), 1'b1, "R12");

    // full segments, same tags in every segment
    do_inval();
    for (int s = 0; s < 8; s++) for (int i = 0; i < W; i++) access(mk(32'h300 + i, s, i), 1'b1, "R8");
    for (int s = 0; s < 8; s++) for (int i = 0; i < W; i++) access(mk(32'h300 + i, s, (i + 3) % 8), 1'b1, "R8");

    // round-robin wraps to the base
    do_inval();
    @(negedge clk); base = WW'(2);
    for (int i = 0; i < W - 2; i++) access(mk(32'h500 + i, 3, 0), 1'b1, "R9");
    access(mk(32'h500 + W - 2, 3, 0), 1'b1, "R9");
    for (int i = 1; i <= W - 2; i++) access(mk(32'h500 + i, 3, 0), 1'b1, "R9");
    access(mk(32'h500, 3, 0), 1'b1, "R9");

    // lockdown in round-robin mode
    do_inval();
    @(negedge clk); base = '0;
    for (int i = 0; i < W; i++) access(mk(32'h600 + i, 5, 0), 1'b1, "R10");
    @(negedge clk); base = WW'(3);
    for (int i = 0; i < 2 * W; i++) access(mk(32'h700 + i, 5, 0), 1'b1, "R10");
    for (int s = 0; s < 3; s++) access(mk(stag[5][s], 5, 1), 1'b1, "R10");

    // lockdown in random mode
    do_inval();
    @(negedge clk); base = '0;
    for (int i = 0; i < W; i++) access(mk(32'h800 + i, 6, 0), 1'b1, "R11");
    for (int s = 0; s < 5; s++) locked[s] = stag[6][s];
    @(negedge clk); rrm = 1'b0; base = WW'(5);
    for (int i = 0; i < 3 * W; i++) begin
      fetch(mk(32'h900 + i, 6, 2), 1'b1, 1'b0, d, cyc, nt);
      chk(d == memword(mk(32'h900 + i, 6, 2), mem_gen), "R11 random fill data",
          64'(d), 64'(memword(mk(32'h900 + i, 6, 2), mem_gen)));
    end
    for (int s = 0; s < 5; s++) begin
      fetch(mk(locked[s], 6, 4), 1'b1, 1'b0, d, cyc, nt);
      chk(nt == 0 && cyc == 0, "R10 R11 locked line kept", 64'(nt), 0);
    end
    fetch(mk(32'h900 + 3 * W - 1, 6, 2), 1'b1, 1'b0, d, cyc, nt);
    chk(nt == 0, "R11 newest random fill present", 64'(nt), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule